// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Stage

This block is the fetch stage of a small in-order core that interleaves several hardware threads cycle by cycle. Each thread has its own program counter and its own pending-fetch register. In every cycle a round-robin selector chooses one thread that is not stalled and whose pending register is free. It drives that thread's PC to a combinational instruction-memory read port and captures the returned word in the thread's register.

A static rule predicts the next PC from the fetched word. A conditional branch with a negative displacement is taken, which covers backward loops. A branch with zero or positive displacement, and any other instruction, falls through to PC + 4.

Fetched entries leave on a valid/ready output stream. A second round-robin selector picks among threads with a pending entry. An offered entry stays on the port, unchanged, until the consumer accepts it. While a thread's entry is waiting, that thread is not fetched again. This is how back-pressure reaches the fetch selector.

A redirect port from later stages overwrites one thread's PC. In the same cycle it throws away that thread's pending entry.

Top module: `mt_fetch`

## Requirements
- R1: During reset and after it, every PC holds the reset vector (default 0x1000) and no entry is offered. The first fetch after reset is from thread 0 at the reset vector.
- R2: With no stalls and a consumer that is always ready, fetches and deliveries rotate through the threads in the order 0, 1, 2, 3, 0, and so on, one thread per cycle.
- R3: A thread whose stall bit is high is never fetched, and the rotation skips it. When every thread is stalled, imem_req_o is low and no new entries appear.
- R4: A word that is not a branch, or a branch with a displacement of zero or more, gives predicted-taken 0 and advances the thread's PC by 4.
- R5: A branch is a word with bits [31:26] equal to 6'h04. When bit 15 of its signed 16-bit word displacement in bits [15:0] is 1, the branch is predicted taken and the thread's PC becomes PC + displacement * 4.
- R6: Each thread holds at most one undelivered entry. A thread with an entry still waiting is not fetched unless that entry is accepted in the same cycle. With the consumer not ready, imem_req_o drops once every thread holds an entry.
- R7: While out_valid_o is high and out_ready_i is low, the offered entry (thread, PC, word, prediction) stays unchanged in the next cycle. A redirect of the offered thread is the only exception.
- R8: A redirect loads the target into the named thread's PC at the next edge. That thread's pending entry is not offered in the redirect cycle and is discarded, and the thread is not fetched in that cycle. Other threads are unaffected.
- R9: Every delivered entry carries the thread id, the PC it was fetched from, and the word the memory returned for that PC. Each thread's PCs follow its own predicted path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | NTHR | Per-thread fetch hold; bit t blocks thread t |
| imem_req_o | output | 1 | A fetch is issued this cycle |
| imem_addr_o | output | 32 | Fetch address (selected thread's PC) |
| imem_rdata_i | input | 32 | Instruction word, combinational reply to imem_addr_o |
| redir_valid_i | input | 1 | Redirect request |
| redir_tid_i | input | log2(NTHR) | Thread to redirect |
| redir_pc_i | input | 32 | Redirect target address |
| out_valid_o | output | 1 | An entry is offered |
| out_ready_i | input | 1 | Consumer accepts the offered entry |
| out_tid_o | output | log2(NTHR) | Thread id of the entry |
| out_pc_o | output | 32 | PC the entry was fetched from |
| out_insn_o | output | 32 | Fetched instruction word |
| out_taken_o | output | 1 | Static prediction for the word |

## Verification
A fetch appears on the output port one cycle after the edge that captures it. A redirect shows on imem_addr_o in the cycle after the redirect edge, and its masking of the pending entry is visible in the redirect cycle itself. The bench drives every input 1 ns after the rising edge and samples at the falling edge. Each check therefore sees the state settled after exactly the edges the requirement counts. A per-thread reference model, advanced on each accepted entry and reset by each redirect, gives the expected PC, word and prediction. A queue filled by the driver holds the expected thread order after reset.

// File: rtl/mt_fetch_pkg.sv
package mt_fetch_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] insn;
    logic              taken;
  } fetch_ent_t;
endpackage

// File: rtl/mt_fetch_pred.sv
module mt_fetch_pred
  import mt_fetch_pkg::*;
#(
  parameter int          OPC_W  = 6,
  parameter int          DISP_W = 16,
  parameter logic [5:0]  BR_OPC = 6'h04
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] insn_i,
  output logic              taken_o,
  output logic [WORD_W-1:0] next_pc_o
);
  localparam int EXT_W = WORD_W - DISP_W - 2;

  logic [OPC_W-1:0]  opc;
  logic [DISP_W-1:0] disp;
  logic              is_br;
  logic [WORD_W-1:0] offset;

  assign opc    = insn_i[WORD_W-1 -: OPC_W];
  assign disp   = insn_i[DISP_W-1:0];
  assign is_br  = (opc == BR_OPC[OPC_W-1:0]);
  assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};

  always_comb begin
    taken_o   = is_br && disp[DISP_W-1];
    next_pc_o = taken_o ? (pc_i + offset) : (pc_i + WORD_W'(4));
  end
endmodule

// File: rtl/mt_fetch_rr.sv
module mt_fetch_rr #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt,
  output logic [W-1:0] gnt_idx,
  output logic         any
);
  logic [W-1:0] ptr_q;

  always_comb begin
    logic [W-1:0] cand;
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      cand = W'(ptr_q + W'(k));
      if (!any && req[cand]) begin
        any     = 1'b1;
        gnt_idx = cand;
      end
    end
    gnt = any ? (N'(1) << gnt_idx) : '0;
  end

  // A grant not taken is offered again first in the next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= W'(N - 1);
    else if (any) ptr_q <= take ? gnt_idx : W'(gnt_idx - W'(1));
  end

  a_r2_grant_within_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0) && (any == (req != '0)));

  a_r7_retry_same: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !take) |=> (!req[$past(gnt_idx)] || (gnt_idx == $past(gnt_idx))));
endmodule

// File: rtl/mt_fetch_slot.sv
module mt_fetch_slot
  import mt_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       clr,
  input  logic       pop,
  input  fetch_ent_t wdata,
  output logic       valid,
  output fetch_ent_t rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rdata <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (wr) begin
      valid <= 1'b1;
      rdata <= wdata;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid);

  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |-> (!valid || pop));
endmodule

// File: rtl/mt_fetch.sv
module mt_fetch
  import mt_fetch_pkg::*;
#(
  parameter int              NTHR      = 4,
  parameter logic [31:0]     RESET_VEC = 32'h0000_1000,
  parameter logic [5:0]      BR_OPC    = 6'h04,
  localparam int             TW        = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   stall_i,
  output logic              imem_req_o,
  output logic [WORD_W-1:0] imem_addr_o,
  input  logic [WORD_W-1:0] imem_rdata_i,
  input  logic              redir_valid_i,
  input  logic [TW-1:0]     redir_tid_i,
  input  logic [WORD_W-1:0] redir_pc_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TW-1:0]     out_tid_o,
  output logic [WORD_W-1:0] out_pc_o,
  output logic [WORD_W-1:0] out_insn_o,
  output logic              out_taken_o
);
  logic [NTHR-1:0]   redir_hit;
  logic [NTHR-1:0]   slot_v;
  logic [NTHR-1:0]   pop;
  logic [NTHR-1:0]   fetch_req, fetch_gnt;
  logic [NTHR-1:0]   out_req, out_gnt;
  logic [TW-1:0]     fetch_idx, out_idx;
  logic              fetch_any, out_any;
  logic [WORD_W-1:0] pc_arr [NTHR];
  fetch_ent_t        ent_arr [NTHR];
  fetch_ent_t        new_ent;
  logic              pred_taken;
  logic [WORD_W-1:0] pred_next;

  // Output selection: pending entries, minus a thread being redirected.
  assign out_req = slot_v & ~redir_hit;

  mt_fetch_rr #(.N(NTHR)) u_out_rr (
    .clk, .rst_n,
    .req     (out_req),
    .take    (out_ready_i),
    .gnt     (out_gnt),
    .gnt_idx (out_idx),
    .any     (out_any)
  );

  assign pop = out_gnt & {NTHR{out_ready_i}};

  // Fetch selection: not stalled, register free or draining, not redirected.
  assign fetch_req = ~stall_i & (~slot_v | pop) & ~redir_hit;

  mt_fetch_rr #(.N(NTHR)) u_fetch_rr (
    .clk, .rst_n,
    .req     (fetch_req),
    .take    (1'b1),
    .gnt     (fetch_gnt),
    .gnt_idx (fetch_idx),
    .any     (fetch_any)
  );

  assign imem_req_o  = fetch_any;
  assign imem_addr_o = pc_arr[fetch_idx];

  mt_fetch_pred #(.BR_OPC(BR_OPC)) u_pred (
    .pc_i      (imem_addr_o),
    .insn_i    (imem_rdata_i),
    .taken_o   (pred_taken),
    .next_pc_o (pred_next)
  );

  assign new_ent = '{pc: imem_addr_o, insn: imem_rdata_i, taken: pred_taken};

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [WORD_W-1:0] pc_q;

    assign redir_hit[t] = redir_valid_i && (redir_tid_i == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pc_q <= RESET_VEC;
      else if (redir_hit[t]) pc_q <= redir_pc_i;
      else if (fetch_gnt[t]) pc_q <= pred_next;
    end

    assign pc_arr[t] = pc_q;

    mt_fetch_slot u_slot (
      .clk, .rst_n,
      .wr    (fetch_gnt[t]),
      .clr   (redir_hit[t]),
      .pop   (pop[t]),
      .wdata (new_ent),
      .valid (slot_v[t]),
      .rdata (ent_arr[t])
    );
  end

  assign out_valid_o = out_any;
  assign out_tid_o   = out_idx;
  assign out_pc_o    = ent_arr[out_idx].pc;
  assign out_insn_o  = ent_arr[out_idx].insn;
  assign out_taken_o = ent_arr[out_idx].taken;

  a_r3_no_stalled_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_any |-> !stall_i[fetch_idx]);

  a_r8_redirect_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i |=> (pc_arr[$past(redir_tid_i)] == $past(redir_pc_i)));

  a_r8_no_fetch_redirected: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_any && redir_valid_i) |-> (fetch_idx != redir_tid_i));

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !(redir_valid_i && redir_tid_i == out_tid_o))
    |=> ((redir_valid_i && redir_tid_i == $past(out_tid_o)) ||
         (out_valid_o && $stable(out_tid_o) && $stable(out_pc_o) &&
          $stable(out_insn_o) && $stable(out_taken_o))));

  a_r4_step_by_four: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_any && !pred_taken && !redir_valid_i)
    |=> (pc_arr[$past(fetch_idx)] == $past(imem_addr_o) + 32'd4));
endmodule

// File: tb/sim_mt_fetch.sv
`timescale 1ns/100ps
module sim_mt_fetch;
  localparam int          NT = 4;
  localparam int          TW = 2;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] stall;
  logic          imem_req;
  logic [31:0]   imem_addr, imem_rdata;
  logic          redir_valid;
  logic [TW-1:0] redir_tid;
  logic [31:0]   redir_pc;
  logic          out_valid, out_ready, out_taken;
  logic [TW-1:0] out_tid;
  logic [31:0]   out_pc, out_insn;

  always #2.5 clk = ~clk;

  mt_fetch #(.NTHR(NT), .RESET_VEC(RV)) u0 (
    .clk, .rst_n,
    .stall_i       (stall),
    .imem_req_o    (imem_req),
    .imem_addr_o   (imem_addr),
    .imem_rdata_i  (imem_rdata),
    .redir_valid_i (redir_valid),
    .redir_tid_i   (redir_tid),
    .redir_pc_i    (redir_pc),
    .out_valid_o   (out_valid),
    .out_ready_i   (out_ready),
    .out_tid_o     (out_tid),
    .out_pc_o      (out_pc),
    .out_insn_o    (out_insn),
    .out_taken_o   (out_taken)
  );

  // Word 5 of each 256-byte block: backward branch (-3 words).
  // Word 9: forward branch (+2). Word 12: zero displacement. Others: non-branch.
  function automatic logic [31:0] mem_f(input logic [31:0] a);
    case (a[7:2])
      6'd5:    return {6'h04, 10'h0, 16'hFFFD};
      6'd9:    return {6'h04, 10'h0, 16'h0002};
      6'd12:   return {6'h04, 10'h0, 16'h0000};
      default: return {6'h01, a[25:0]};
    endcase
  endfunction

  function automatic logic taken_f(input logic [31:0] w);
    return (w[31:26] == 6'h04) && w[15];
  endfunction

  function automatic logic [31:0] next_f(input logic [31:0] pc, input logic [31:0] w);
    return taken_f(w) ? pc + {{14{w[15]}}, w[15:0], 2'b00} : pc + 32'd4;
  endfunction

  assign imem_rdata = mem_f(imem_addr);

  int          n_chk = 0, n_fail = 0;
  int          n_back = 0, n_fwd = 0, n_acc = 0;
  logic [31:0] exp_pc [NT];
  int          exp_q[$];
  int          log_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: every accepted entry is compared with the per-thread model.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [31:0] w;
      int          t;
      t = int'(out_tid);
      w = mem_f(exp_pc[t]);
      n_acc++;
      log_q.push_back(t);
      if (exp_q.size() > 0) begin
        chk(t == exp_q[0], "R2", "thread order", 32'(t), 32'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      chk(out_pc == exp_pc[t], "R9", "entry pc", out_pc, exp_pc[t]);
      chk(out_insn == w, "R9", "entry word", out_insn, w);
      if (taken_f(w)) begin
        n_back++;
        chk(out_taken == 1'b1, "R5", "backward branch taken", 32'(out_taken), 32'd1);
      end else begin
        if (w[31:26] == 6'h04) n_fwd++;
        chk(out_taken == 1'b0, "R4", "fall-through prediction", 32'(out_taken), 32'd0);
      end
      exp_pc[t] = next_f(exp_pc[t], w);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'(n_acc), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [TW-1:0] h;
    logic [31:0]   hp;
    int            nlog;
    bit            ok;
    rst_n = 1'b0; stall = '0; out_ready = 1'b1;
    redir_valid = 1'b0; redir_tid = '0; redir_pc = '0;
    for (int t = 0; t < NT; t++) exp_pc[t] = RV;
    for (int i = 0; i < 8; i++) exp_q.push_back(i % NT);

    // R1: reset state
    step(3);
    chk(out_valid == 1'b0, "R1", "no offer in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_req == 1'b1, "R1", "fetch after reset", 32'(imem_req), 32'd1);
    chk(imem_addr == RV, "R1", "reset vector", imem_addr, RV);
    chk(out_valid == 1'b0, "R1", "no offer before first edge", 32'(out_valid), 32'd0);

    // R2: rotation order after reset
    step(12);
    chk(exp_q.size() == 0, "R2", "order queue drained", 32'(exp_q.size()), 32'd0);

    // R3: threads 1 and 3 stalled
    stall = 4'b1010;
    step(3);
    log_q.delete();
    step(10);
    ok = (log_q.size() >= 8);
    for (int i = 0; i < log_q.size(); i++) begin
      if (log_q[i] != 0 && log_q[i] != 2) ok = 1'b0;
      if (i > 0 && log_q[i] == log_q[i-1]) ok = 1'b0;
    end
    chk(ok, "R3", "only threads 0 and 2, alternating", 32'(log_q.size()), 32'd8);

    // R3: all stalled
    stall = 4'hF;
    step(3);
    @(negedge clk);
    chk(imem_req == 1'b0, "R3", "no fetch when all stalled", 32'(imem_req), 32'd0);
    chk(out_valid == 1'b0, "R3", "nothing pending", 32'(out_valid), 32'd0);
    nlog = log_q.size();
    step(4);
    chk(log_q.size() == nlog, "R3", "no new entries", 32'(log_q.size()), 32'(nlog));

    // R6/R7: back-pressure
    out_ready = 1'b0; stall = '0;
    step(6);
    @(negedge clk);
    chk(imem_req == 1'b0, "R6", "fetch stops with all registers full", 32'(imem_req), 32'd0);
    chk(out_valid == 1'b1, "R7", "entry offered", 32'(out_valid), 32'd1);
    h = out_tid; hp = out_pc;
    step(3);
    @(negedge clk);
    chk(out_tid == h, "R7", "offered thread held", 32'(out_tid), 32'(h));
    chk(out_pc == hp, "R7", "offered pc held", out_pc, hp);

    // R8: redirect the offered thread
    step(1);
    redir_valid = 1'b1; redir_tid = h; redir_pc = 32'h0000_1020;
    exp_pc[h] = 32'h0000_1020;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_tid != h, "R8", "redirected entry not offered",
        32'(out_tid), 32'(h));
    @(posedge clk); #1;
    redir_valid = 1'b0;
    @(negedge clk);
    chk(imem_req == 1'b1, "R8", "redirected thread refetched", 32'(imem_req), 32'd1);
    chk(imem_addr == 32'h0000_1020, "R8", "fetch from target", imem_addr, 32'h0000_1020);

    out_ready = 1'b1;
    step(40);

    // R8: redirect while streaming
    redir_valid = 1'b1; redir_tid = 2'd1; redir_pc = 32'h0000_1040;
    exp_pc[1] = 32'h0000_1040;
    step(1);
    redir_valid = 1'b0;
    step(40);

    // Mixed stalls and back-pressure
    for (int i = 0; i < 30; i++) begin
      out_ready = (i % 3) != 0;
      stall     = 4'(i * 5) & 4'b0110;
      step(1);
    end
    out_ready = 1'b1; stall = '0;
    step(10);

    chk(n_back > 0, "R5", "backward branches seen", 32'(n_back), 32'd1);
    chk(n_fwd > 0, "R4", "forward or zero branches seen", 32'(n_fwd), 32'd1);
    chk(n_acc > 100, "R9", "entries delivered", 32'(n_acc), 32'd100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule